// File: doc/BRIEF.md
# Offset-Corrected Sample Formatter

This datapath sits between a converter's raw result and the sample buffer that follows it. A one-shot calibration command asks the analog front end to apply a zero input by raising a zero-input request. The next converted sample is taken as the offset. That sample is stored in an offset register and is not passed on. From then on, every sample has the stored offset subtracted before it leaves the block.

The subtraction works on signed two's-complement values and clamps at the limits of the sample width, so a large offset cannot make the result wrap. The corrected value is then sent out in one of two codings, chosen per sample by a format input: two's complement, or offset binary. Offset binary is formed by inverting the most significant bit.

Top module: `ofs_corrector`

## Requirements
- R1: After reset, out_valid and zero_req are 0 and the offset register holds 0, so the first samples pass through uncorrected.
- R2: When cal_start is 1 and zero_req is 0, zero_req is 1 from the next cycle on. It stays 1 until a cycle in which raw_valid is 1, and it is 0 from the cycle after that.
- R3: A sample accepted while zero_req is 1 is the calibration sample and produces no output: out_valid stays 0 in the following cycle.
- R4: The calibration sample's raw value becomes the offset. Every later sample leaves the block as raw_data minus that offset, both read as signed two's-complement numbers.
- R5: The difference saturates. Results above the largest positive code give 0x7FF, and results below the most negative code give 0x800 (two's-complement coding, 12-bit default).
- R6: With fmt_bin = 0, out_data is the corrected value in two's complement. With fmt_bin = 1, out_data is the same value with its most significant bit inverted (offset binary). fmt_bin is sampled together with raw_valid.
- R7: A sample accepted while zero_req is 0 appears on out_data with out_valid = 1 exactly one cycle later.
- R8: cal_start has no effect while zero_req is already 1. The request stays up, and the next sample is still taken as the calibration sample.
- R9: A new calibration replaces the stored offset with the new raw calibration sample. The new offset is neither corrected by the old one nor added to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_data | input | SAMPLE_W | Raw converter sample, two's complement |
| raw_valid | input | 1 | Raw sample strobe |
| cal_start | input | 1 | Start an offset calibration |
| fmt_bin | input | 1 | Output coding: 0 two's complement, 1 offset binary |
| out_data | output | SAMPLE_W | Corrected, formatted sample |
| out_valid | output | 1 | Output sample strobe |
| zero_req | output | 1 | Request to the front end to apply a zero input |

## Verification
The assertions assume that raw_valid is a single-cycle strobe per sample. They also assume that the front end delivers the calibration sample whenever it chooses, with no minimum delay after zero_req rises. The stimulus therefore includes a calibration sample in the cycle right after the request and also after several idle cycles. It includes cal_start in the same cycle as a sample, and a repeated cal_start during a pending request. The values pushed through the subtraction include both extremes of the code range, so that both saturation limits are reached.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;
  typedef enum logic {FMT_TWOS = 1'b0, FMT_BIN = 1'b1} fmt_e;
endpackage

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl #(
  parameter int unsigned W = ofs_pkg::SAMPLE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cal_start,
  input  logic         raw_valid,
  input  logic [W-1:0] raw_data,
  output logic         zero_req,
  output logic [W-1:0] offset
);
  logic take_cal;
  assign take_cal = zero_req && raw_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_req <= 1'b0;
      offset   <= '0;
    end else if (take_cal) begin
      zero_req <= 1'b0;
      offset   <= raw_data;
    end else if (cal_start) begin
      zero_req <= 1'b1;
    end
  end

  // R2: request raised after a start command
  assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
    cal_start && !zero_req |=> zero_req);
  // R2: request held until a sample arrives
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    zero_req && !raw_valid |=> zero_req);
  // R2: request dropped once the sample is seen
  assert_req_drop_R2: assert property (@(posedge clk) disable iff (rst)
    zero_req && raw_valid |=> !zero_req);
  // R4: offset changes only on a calibration sample
  assert_offset_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !(zero_req && raw_valid) |=> $stable(offset));
endmodule

// File: rtl/ofs_sat_sub.sv
module ofs_sat_sub #(
  parameter int unsigned W = ofs_pkg::SAMPLE_W_DEF
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] diff;
  assign diff = {a[W-1], a} - {b[W-1], b};

  always_comb begin
    if (diff[W] == diff[W-1]) y = diff[W-1:0];
    else if (diff[W])         y = NEG_MIN;
    else                      y = POS_MAX;
  end
endmodule

// File: rtl/ofs_fmt_reg.sv
module ofs_fmt_reg #(
  parameter int unsigned W = ofs_pkg::SAMPLE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         fmt_bin,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  import ofs_pkg::*;
  logic [W-1:0] coded;
  fmt_e         fmt;

  assign fmt = fmt_e'(fmt_bin);
  always_comb begin
    coded = in_data;
    if (fmt == FMT_BIN) coded[W-1] = ~in_data[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= coded;
    end
  end

  // R6: output word only changes with a valid strobe
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

// File: rtl/ofs_corrector.sv
module ofs_corrector #(
  parameter int unsigned SAMPLE_W = ofs_pkg::SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] raw_data,
  input  logic                raw_valid,
  input  logic                cal_start,
  input  logic                fmt_bin,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_valid,
  output logic                zero_req
);
  logic [SAMPLE_W-1:0] offset;
  logic [SAMPLE_W-1:0] corrected;
  logic                pass_valid;

  ofs_cal_ctrl #(.W(SAMPLE_W)) u_cal (
    .clk(clk), .rst(rst), .cal_start(cal_start), .raw_valid(raw_valid),
    .raw_data(raw_data), .zero_req(zero_req), .offset(offset));

  ofs_sat_sub #(.W(SAMPLE_W)) u_sub (
    .a(raw_data), .b(offset), .y(corrected));

  assign pass_valid = raw_valid && !zero_req;

  ofs_fmt_reg #(.W(SAMPLE_W)) u_fmt (
    .clk(clk), .rst(rst), .in_valid(pass_valid), .in_data(corrected),
    .fmt_bin(fmt_bin), .out_valid(out_valid), .out_data(out_data));

  // R3: calibration sample never emitted
  assert_cal_hidden_R3: assert property (@(posedge clk) disable iff (rst)
    zero_req && raw_valid |=> !out_valid);
  // R7: normal sample emitted one cycle later
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    raw_valid && !zero_req |=> out_valid);
  // R7: no output without a sample
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    !raw_valid |=> !out_valid);
endmodule

// File: tb/sim_ofs_corrector.sv
module sim_ofs_corrector;
  localparam int W = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] raw_data = '0;
  logic raw_valid = 1'b0, cal_start = 1'b0, fmt_bin = 1'b0;
  logic [W-1:0] out_data;
  logic out_valid, zero_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ofs_corrector #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .raw_data(raw_data), .raw_valid(raw_valid),
    .cal_start(cal_start), .fmt_bin(fmt_bin), .out_data(out_data),
    .out_valid(out_valid), .zero_req(zero_req));

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_off = 0, m_d = 0;
  bit m_req = 0, m_v = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_req = 0; m_off = 0; m_v = 0; m_d = 0;
    end else begin
      bit old_req;
      int diff;
      old_req = m_req;
      m_v = raw_valid && !old_req;
      if (m_v) begin
        diff = sx(raw_data) - m_off;
        if (diff > 2047) diff = 2047;
        if (diff < -2048) diff = -2048;
        m_d = diff & 'hFFF;
        if (fmt_bin) m_d = m_d ^ 'h800;
      end
      if (old_req && raw_valid) begin
        m_off = sx(raw_data);
        m_req = 0;
      end else if (cal_start) m_req = 1;
    end
  end

  always @(negedge clk) if (!rst) begin
    check(zero_req == m_req, "R2 zero_req", zero_req, m_req);
    check(out_valid == m_v, "R3/R7 out_valid", out_valid, m_v);
    if (m_v) check(out_data == m_d[W-1:0], "R4 out_data", out_data, m_d);
  end

  task automatic send(input logic [W-1:0] v, input bit f);
    @(negedge clk);
    raw_data = v; fmt_bin = f; raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic start_cal();
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  initial begin
    #400000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 0 && zero_req == 0, "R1 reset", {out_valid, zero_req}, 0);
    send(12'h123, 0);
    check(out_valid && out_data == 12'h123, "R1 zero offset", out_data, 12'h123);
    send(12'h123, 1);
    check(out_data == 12'h923, "R6 binary", out_data, 12'h923);
    start_cal();
    check(zero_req == 1, "R2 raise", zero_req, 1);
    repeat (2) @(negedge clk);
    start_cal();
    check(zero_req == 1, "R8 repeat start", zero_req, 1);
    send(12'h010, 0);
    check(out_valid == 0, "R3 hidden", out_valid, 0);
    check(zero_req == 0, "R2 drop", zero_req, 0);
    send(12'h110, 0);
    check(out_data == 12'h100, "R4 subtract", out_data, 12'h100);
    send(12'h800, 0);
    check(out_data == 12'h800, "R5 neg sat", out_data, 12'h800);
    send(12'h800, 1);
    check(out_data == 12'h000, "R5 neg sat bin", out_data, 12'h000);
    send(12'h000, 0);
    check(out_data == 12'hFF0, "R6 twos neg", out_data, 12'hFF0);
    start_cal();
    send(12'hFF0, 0);
    send(12'h7F8, 0);
    check(out_data == 12'h7FF, "R5 pos sat / R9 replace", out_data, 12'h7FF);
    send(12'h000, 0);
    check(out_data == 12'h010, "R9 replace", out_data, 12'h010);
    // cal_start together with a sample: sample still emitted
    @(negedge clk);
    raw_data = 12'h020; raw_valid = 1'b1; cal_start = 1'b1; fmt_bin = 1'b0;
    @(negedge clk);
    raw_valid = 1'b0; cal_start = 1'b0;
    check(out_valid && out_data == 12'h030, "R7 sample with start", out_data, 12'h030);
    send(12'h000, 0);
    check(out_valid == 0, "R3 immediate cal", out_valid, 0);
    // mixed stream checked against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      raw_valid = ($urandom % 3) != 0;
      raw_data = $urandom;
      if (i % 50 == 7) raw_data = 12'h7FF;
      if (i % 50 == 8) raw_data = 12'h800;
      fmt_bin = $urandom;
      cal_start = ($urandom % 23) == 0;
    end
    @(negedge clk);
    raw_valid = 1'b0; cal_start = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule